// File: doc/BRIEF.md
# Indexed External Data Strobe Port

This block is one per-socket data register on a byte-wide indexed register bus. The host reaches it in two steps. It writes a primary index through the index port. It then reads or writes through the data port. One primary index acts as a pointer: data-port writes to it set an extended index. A second primary index is the extended window. Data-port accesses there reach the register that the extended index selects. Two extended registers live here: an 8-bit data register and an 8-bit mode control register.

Two bits of the control register select what the data register is for:

- **Scratchpad.** The register behaves as plain storage.
- **External read port.** An active-high strobe pin enables an outside buffer, which drives the upper data byte during a host read of the data register. The block stays off the bus for that read.
- **External write port.** The same strobe latches the upper data byte into an outside register during a host write. The data register keeps a copy, so host reads still return the last value written.

The fourth code is reserved and behaves as the scratchpad. The strobe is combinational with the decoded host access. It is high only while the host read or write strobe is active for this exact index pair.

Top module: `ext_data_strobe_port`

## Requirements
- R1: After reset, the primary index, extended index, control and data registers all read 00h, and `extStrobe` and `rdOe` are low.
- R2: A write with `ioAddr`=0 loads the primary index. A read with `ioAddr`=0 returns it on `rdData` with `rdOe` high, in the same cycle.
- R3: Control bits 4 and 3 form the mode code {bit4, bit3}. With code 00, data-port writes at primary index 2Fh and extended index 0Ah store `wrData`. Reads there return the stored value with `rdOe` high. `extStrobe` stays low throughout.
- R4: At primary index 2Fh, extended index 0Bh is the 8-bit control register. It is read and written through the data port. Writing it never raises `extStrobe`.
- R5: With code 01 (bit 3 set), a data-register read raises `extStrobe` in the same cycle as `ioRd`, with `rdOe` low. Writes in this mode do not raise `extStrobe`, but they still update the data register.
- R6: With code 10 (bit 4 set), a data-register write raises `extStrobe` in the same cycle as `ioWr` and stores `wrData`. Reads in this mode return the stored value with `rdOe` high and `extStrobe` low.
- R7: Code 11 behaves as the scratchpad. `extStrobe` never rises, and reads return the stored value.
- R8: Data-port accesses at any other primary index, or at an extended index other than 0Ah or 0Bh, leave `extStrobe` low. They do not change the data register. A read there leaves `rdOe` low with `rdData` 00h.
- R9: At primary index 2Eh, a data-port write loads the extended index and a data-port read returns it.
- R10: A cycle in which `ioRd` and `ioWr` are both high is ignored. No register changes, `extStrobe` stays low and `rdOe` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 1 | 0 selects the index port, 1 selects the data port |
| ioRd | input | 1 | Host I/O read strobe, active high |
| ioWr | input | 1 | Host I/O write strobe, active high |
| wrData | input | 8 | Low data byte from the host on writes |
| rdData | output | 8 | Low data byte returned on reads; 00h when `rdOe` is low |
| rdOe | output | 1 | High while the block drives `rdData` onto the bus |
| extStrobe | output | 1 | Active-high read-buffer enable or write-latch enable for the upper data byte |

## Verification
`extStrobe`, `rdOe` and `rdData` are combinational with the host strobes, so each of them is due in the same cycle as the access. The bench drives each access on a falling edge and samples these outputs 2 ns later, well before the rising edge.

Register loads take effect on the rising edge that ends the access. Their results are therefore checked by a later access, one cycle or more afterwards. This holds for the index, the pointer, the control and the data register. The ignored-access requirements are checked this way: after the stray cycle, the data register is read back through the normal data port.

// File: rtl/ext_port_pkg.sv
package ext_port_pkg;

  // Source chosen for the read data bus.
  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_INDEX = 3'd1,
    SEL_PTR   = 3'd2,
    SEL_CTRL  = 3'd3,
    SEL_DATA  = 3'd4
  } rd_sel_e;

  // Role of the data register, coded as {write-strobe bit, read-strobe bit}.
  typedef enum logic [1:0] {
    MODE_SCRATCH = 2'b00,
    MODE_RDPORT  = 2'b01,
    MODE_WRPORT  = 2'b10,
    MODE_RSVD    = 2'b11
  } port_mode_e;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic    loadIndex;
    logic    loadPtr;
    logic    loadCtrl;
    logic    loadData;
    rd_sel_e rdSel;
  } dp_cmd_t;

  localparam int unsigned DEF_DATA_W   = 8;
  localparam logic [7:0]  DEF_PTR_IDX  = 8'h2E;
  localparam logic [7:0]  DEF_WIN_IDX  = 8'h2F;
  localparam logic [7:0]  DEF_DATA_EXT = 8'h0A;
  localparam logic [7:0]  DEF_CTRL_EXT = 8'h0B;

  function automatic port_mode_e decodeMode(input logic [1:0] bits);
    port_mode_e m;
    case (bits)
      2'b01:   m = MODE_RDPORT;
      2'b10:   m = MODE_WRPORT;
      2'b11:   m = MODE_RSVD;
      default: m = MODE_SCRATCH;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ext_port_ctrl.sv
module ext_port_ctrl
  import ext_port_pkg::*;
#(
  parameter int unsigned     DATA_W   = DEF_DATA_W,
  parameter logic [DATA_W-1:0] PTR_IDX  = DEF_PTR_IDX,
  parameter logic [DATA_W-1:0] WIN_IDX  = DEF_WIN_IDX,
  parameter logic [DATA_W-1:0] DATA_EXT = DEF_DATA_EXT,
  parameter logic [DATA_W-1:0] CTRL_EXT = DEF_CTRL_EXT
) (
  input  logic              ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [DATA_W-1:0] idxReg,
  input  logic [DATA_W-1:0] extReg,
  input  logic [1:0]        modeBits,
  output dp_cmd_t           cmd,
  output logic              extStrobe
);

  logic       rdAct;
  logic       wrAct;
  logic       onPtr;
  logic       onWin;
  logic       onData;
  logic       onCtrl;
  port_mode_e mode;

  // A cycle with both host strobes high counts as no access.
  assign rdAct  = ioRd & ~ioWr;
  assign wrAct  = ioWr & ~ioRd;

  assign onPtr  = ioAddr & (idxReg == PTR_IDX);
  assign onWin  = ioAddr & (idxReg == WIN_IDX);
  assign onData = onWin & (extReg == DATA_EXT);
  assign onCtrl = onWin & (extReg == CTRL_EXT);
  assign mode   = decodeMode(modeBits);

  always_comb begin
    cmd           = '0;
    cmd.rdSel     = SEL_NONE;
    cmd.loadIndex = wrAct & ~ioAddr;
    cmd.loadPtr   = wrAct & onPtr;
    cmd.loadCtrl  = wrAct & onCtrl;
    cmd.loadData  = wrAct & onData;
    if (rdAct) begin
      if (!ioAddr) begin
        cmd.rdSel = SEL_INDEX;
      end else if (onPtr) begin
        cmd.rdSel = SEL_PTR;
      end else if (onCtrl) begin
        cmd.rdSel = SEL_CTRL;
      end else if (onData && mode != MODE_RDPORT) begin
        cmd.rdSel = SEL_DATA;
      end
    end
  end

  // The strobe follows the decoded access combinationally.
  always_comb begin
    extStrobe = 1'b0;
    if (onData) begin
      case (mode)
        MODE_RDPORT: extStrobe = rdAct;
        MODE_WRPORT: extStrobe = wrAct;
        default:     extStrobe = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/ext_port_dp.sv
module ext_port_dp
  import ext_port_pkg::*;
#(
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned WR_EN_BIT = 4,
  parameter int unsigned RD_EN_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_cmd_t           cmd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] idxReg,
  output logic [DATA_W-1:0] extReg,
  output logic [DATA_W-1:0] dataReg,
  output logic [1:0]        modeBits,
  output logic [DATA_W-1:0] rdData,
  output logic              rdOe
);

  logic [DATA_W-1:0] ctrlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg  <= '0;
      extReg  <= '0;
      ctrlReg <= '0;
      dataReg <= '0;
    end else begin
      if (cmd.loadIndex) idxReg  <= wrData;
      if (cmd.loadPtr)   extReg  <= wrData;
      if (cmd.loadCtrl)  ctrlReg <= wrData;
      if (cmd.loadData)  dataReg <= wrData;
    end
  end

  assign modeBits = {ctrlReg[WR_EN_BIT], ctrlReg[RD_EN_BIT]};

  always_comb begin
    unique case (cmd.rdSel)
      SEL_INDEX: rdData = idxReg;
      SEL_PTR:   rdData = extReg;
      SEL_CTRL:  rdData = ctrlReg;
      SEL_DATA:  rdData = dataReg;
      default:   rdData = '0;
    endcase
  end

  assign rdOe = (cmd.rdSel != SEL_NONE);

endmodule

// File: rtl/ext_data_strobe_port.sv
module ext_data_strobe_port
  import ext_port_pkg::*;
#(
  parameter int unsigned       DATA_W    = DEF_DATA_W,
  parameter logic [DATA_W-1:0] PTR_IDX   = DEF_PTR_IDX,
  parameter logic [DATA_W-1:0] WIN_IDX   = DEF_WIN_IDX,
  parameter logic [DATA_W-1:0] DATA_EXT  = DEF_DATA_EXT,
  parameter logic [DATA_W-1:0] CTRL_EXT  = DEF_CTRL_EXT,
  parameter int unsigned       WR_EN_BIT = 4,
  parameter int unsigned       RD_EN_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdOe,
  output logic              extStrobe
);

  dp_cmd_t           cmd;
  logic [DATA_W-1:0] idxReg;
  logic [DATA_W-1:0] extReg;
  logic [DATA_W-1:0] dataVal;
  logic [1:0]        modeBits;

  ext_port_ctrl #(
    .DATA_W  (DATA_W),
    .PTR_IDX (PTR_IDX),
    .WIN_IDX (WIN_IDX),
    .DATA_EXT(DATA_EXT),
    .CTRL_EXT(CTRL_EXT)
  ) ctrlI (
    .ioAddr   (ioAddr),
    .ioRd     (ioRd),
    .ioWr     (ioWr),
    .idxReg   (idxReg),
    .extReg   (extReg),
    .modeBits (modeBits),
    .cmd      (cmd),
    .extStrobe(extStrobe)
  );

  ext_port_dp #(
    .DATA_W   (DATA_W),
    .WR_EN_BIT(WR_EN_BIT),
    .RD_EN_BIT(RD_EN_BIT)
  ) dpI (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .wrData  (wrData),
    .idxReg  (idxReg),
    .extReg  (extReg),
    .dataReg (dataVal),
    .modeBits(modeBits),
    .rdData  (rdData),
    .rdOe    (rdOe)
  );

endmodule

// File: rtl/ext_port_chk.sv
module ext_port_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ioAddr,
  input logic              ioRd,
  input logic              ioWr,
  input logic [DATA_W-1:0] wrData,
  input logic              rdOe,
  input logic              extStrobe,
  input logic [DATA_W-1:0] dataVal,
  input logic [1:0]        modeBits
);

  AST_STROBE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    extStrobe |-> (ioAddr && (ioRd != ioWr))) else $error("strobe without access"); // R8

  AST_BOTH_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && ioWr) |-> (!extStrobe && !rdOe)) else $error("dual strobe acted"); // R10

  AST_RDPORT_OFF_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (extStrobe && ioRd) |-> !rdOe) else $error("bus contention"); // R5

  AST_WRPORT_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (extStrobe && ioWr) |=> (dataVal == $past(wrData))) else $error("write copy lost"); // R6

  AST_SCRATCH_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits == 2'b00) |-> !extStrobe) else $error("scratch strobe"); // R3

  AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits == 2'b11) |-> !extStrobe) else $error("reserved strobe"); // R7

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(ioWr && !ioRd && ioAddr) |=> $stable(dataVal)) else $error("data changed"); // R8

endmodule

bind ext_data_strobe_port ext_port_chk #(.DATA_W(DATA_W)) chkI (
  .clk      (clk),
  .rstN     (rstN),
  .ioAddr   (ioAddr),
  .ioRd     (ioRd),
  .ioWr     (ioWr),
  .wrData   (wrData),
  .rdOe     (rdOe),
  .extStrobe(extStrobe),
  .dataVal  (dataVal),
  .modeBits (modeBits)
);

// File: tb/ext_data_strobe_port_tb_top.sv
module ext_data_strobe_port_tb_top;

  localparam int VW = 26;
  localparam int NV = 56;
  localparam int WATCHDOG_NS = 200000;

  // Vector fields: addr, rd, wr, wdata, expStrobe, expOe, expRd, checkRd, req
  function automatic logic [VW-1:0] v(input logic a, input logic r, input logic w,
                                      input logic [7:0] wd, input logic es,
                                      input logic eo, input logic [7:0] erd,
                                      input logic chk, input logic [3:0] req);
    return {a, r, w, wd, es, eo, erd, chk, req};
  endfunction

  localparam logic [VW-1:0] VECS [NV] = '{
    v(0,0,1,8'h2E,0,0,8'h00,0,4'd9),  // R9 point at extended index
    v(1,0,1,8'h0A,0,0,8'h00,0,4'd9),
    v(1,1,0,8'h00,0,1,8'h0A,1,4'd9),  // R9 pointer readback
    v(0,1,0,8'h00,0,1,8'h2E,1,4'd2),  // R2 index readback
    v(0,0,1,8'h2F,0,0,8'h00,0,4'd2),
    v(1,0,1,8'h5A,0,0,8'h00,0,4'd3),  // R3 scratch write
    v(1,1,0,8'h00,0,1,8'h5A,1,4'd3),  // R3 scratch read
    v(0,0,1,8'h2E,0,0,8'h00,0,4'd4),
    v(1,0,1,8'h0B,0,0,8'h00,0,4'd4),
    v(0,0,1,8'h2F,0,0,8'h00,0,4'd4),
    v(1,0,1,8'h08,0,0,8'h00,0,4'd4),  // R4 set read-port code
    v(1,1,0,8'h00,0,1,8'h08,1,4'd4),  // R4 control readback
    v(0,0,1,8'h2E,0,0,8'h00,0,4'd5),
    v(1,0,1,8'h0A,0,0,8'h00,0,4'd5),
    v(0,0,1,8'h2F,0,0,8'h00,0,4'd5),
    v(1,1,0,8'h00,1,0,8'h00,0,4'd5),  // R5 strobe on read, off bus
    v(1,0,1,8'hC3,0,0,8'h00,0,4'd5),  // R5 no strobe on write
    v(0,0,1,8'h2E,0,0,8'h00,0,4'd6),
    v(1,0,1,8'h0B,0,0,8'h00,0,4'd6),
    v(0,0,1,8'h2F,0,0,8'h00,0,4'd6),
    v(1,0,1,8'h10,0,0,8'h00,0,4'd6),  // R6 set write-port code
    v(1,1,0,8'h00,0,1,8'h10,1,4'd4),
    v(0,0,1,8'h2E,0,0,8'h00,0,4'd6),
    v(1,0,1,8'h0A,0,0,8'h00,0,4'd6),
    v(0,0,1,8'h2F,0,0,8'h00,0,4'd6),
    v(1,1,0,8'h00,0,1,8'hC3,1,4'd5),  // R5 write in read-port mode was stored
    v(1,0,1,8'h96,1,0,8'h00,0,4'd6),  // R6 latch strobe on write
    v(1,1,0,8'h00,0,1,8'h96,1,4'd6),  // R6 copy readable, no strobe
    v(0,0,1,8'h2E,0,0,8'h00,0,4'd7),
    v(1,0,1,8'h0B,0,0,8'h00,0,4'd7),
    v(0,0,1,8'h2F,0,0,8'h00,0,4'd7),
    v(1,0,1,8'h18,0,0,8'h00,0,4'd7),  // R7 reserved code
    v(0,0,1,8'h2E,0,0,8'h00,0,4'd7),
    v(1,0,1,8'h0A,0,0,8'h00,0,4'd7),
    v(0,0,1,8'h2F,0,0,8'h00,0,4'd7),
    v(1,0,1,8'h3C,0,0,8'h00,0,4'd7),  // R7 silent write
    v(1,1,0,8'h00,0,1,8'h3C,1,4'd7),  // R7 silent read
    v(0,0,1,8'h2E,0,0,8'h00,0,4'd8),
    v(1,0,1,8'h0B,0,0,8'h00,0,4'd8),
    v(0,0,1,8'h2F,0,0,8'h00,0,4'd8),
    v(1,0,1,8'h10,0,0,8'h00,0,4'd8),  // back to write-port code
    v(0,0,1,8'h2E,0,0,8'h00,0,4'd8),
    v(1,0,1,8'h0C,0,0,8'h00,0,4'd8),
    v(0,0,1,8'h2F,0,0,8'h00,0,4'd8),
    v(1,0,1,8'h77,0,0,8'h00,0,4'd8),  // R8 other extended index
    v(1,1,0,8'h00,0,0,8'h00,1,4'd8),
    v(0,0,1,8'h30,0,0,8'h00,0,4'd8),
    v(1,0,1,8'h55,0,0,8'h00,0,4'd8),  // R8 other primary index
    v(1,1,0,8'h00,0,0,8'h00,1,4'd8),
    v(0,0,1,8'h2E,0,0,8'h00,0,4'd8),
    v(1,0,1,8'h0A,0,0,8'h00,0,4'd8),
    v(0,0,1,8'h2F,0,0,8'h00,0,4'd8),
    v(1,1,1,8'h11,0,0,8'h00,1,4'd10), // R10 both strobes ignored
    v(1,1,0,8'h00,0,1,8'h3C,1,4'd8),  // R8 R10 data unchanged
    v(1,0,1,8'hA5,1,0,8'h00,0,4'd6),
    v(1,1,0,8'h00,0,1,8'hA5,1,4'd6)
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ioAddr = 1'b0;
  logic       ioRd = 1'b0;
  logic       ioWr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       rdOe;
  logic       extStrobe;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  ext_data_strobe_port dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .ioAddr   (ioAddr),
    .ioRd     (ioRd),
    .ioWr     (ioWr),
    .wrData   (wrData),
    .rdData   (rdData),
    .rdOe     (rdOe),
    .extStrobe(extStrobe)
  );

  task automatic check(input string what, input int req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Drive on a falling edge, sample 2 ns later, return to caller before the next fall.
  task automatic access(input logic a, input logic r, input logic w, input logic [7:0] wd);
    @(negedge clk);
    ioAddr = a;
    ioRd   = r;
    ioWr   = w;
    wrData = wd;
    #2;
  endtask

  task automatic goIdle();
    @(negedge clk);
    ioAddr = 1'b0;
    ioRd   = 1'b0;
    ioWr   = 1'b0;
    wrData = 8'h00;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    ioRd = 1'b0;
    ioWr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    #2;
    check("reset strobe", 1, {7'd0, extStrobe}, 8'h00);  // R1
    check("reset rdOe", 1, {7'd0, rdOe}, 8'h00);         // R1
    access(0, 1, 0, 8'h00);
    check("reset index", 1, rdData, 8'h00);              // R1

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      e = VECS[i];
      access(e[25], e[24], e[23], e[22:15]);
      check($sformatf("vec %0d strobe", i), int'(e[3:0]), {7'd0, extStrobe}, {7'd0, e[14]});
      check($sformatf("vec %0d rdOe", i), int'(e[3:0]), {7'd0, rdOe}, {7'd0, e[13]});
      if (e[4]) check($sformatf("vec %0d rdData", i), int'(e[3:0]), rdData, e[12:5]);
    end

    // R1: reset after use clears every register
    goIdle();
    doReset();
    access(0, 1, 0, 8'h00);
    check("R1 index after reset", 1, rdData, 8'h00);
    access(0, 0, 1, 8'h2E);
    access(1, 1, 0, 8'h00);
    check("R1 pointer after reset", 1, rdData, 8'h00);
    access(1, 0, 1, 8'h0B);
    access(0, 0, 1, 8'h2F);
    access(1, 1, 0, 8'h00);
    check("R1 control after reset", 1, rdData, 8'h00);
    access(0, 0, 1, 8'h2E);
    access(1, 0, 1, 8'h0A);
    access(0, 0, 1, 8'h2F);
    access(1, 1, 0, 8'h00);
    check("R1 data after reset", 1, rdData, 8'h00);
    check("R1 R3 no strobe after reset", 1, {7'd0, extStrobe}, 8'h00);
    goIdle();
    #2;
    check("R5 idle strobe low", 5, {7'd0, extStrobe}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(WATCHDOG_NS);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule